// File: doc/BRIEF.md
# Lookup-Table Configurable ALU

A 16-bit arithmetic/logic unit in which every bit is computed by the same small slice. Each slice holds two tiny multiplexers addressed by its two operand bits. One picks a propagate term from four shared lines and the other picks a generate term from two shared lines. The result bit is propagate XOR carry-in. The carry-out is generate OR (propagate AND carry-in).

A decoder turns a 5-bit operation code into the six lookup lines and a few special controls. These controls choose the carry-in, inject a step at bit 1, keep the first operand for a compare, mirror the operand onto both inputs for left shifts, and switch to a separate right-moving path. A byte-mode input narrows the operation to bits 7:0.

The unit is combinational up to one output register stage. Result and flags appear on the clock edge after the inputs are applied.

Top module: `lut_alu`

## Requirements
- R1: After an active-low asynchronous reset, the result and all five flags read 0. Each operation's result and flags appear on the first rising clock edge after its inputs are applied.
- R2: Code 00 gives a+b, code 02 gives a+b+carry_i, and code 18 gives a+1. The carry flag is the unsigned carry-out.
- R3: Code 05 gives a-b, code 03 gives a-b-carry_i, code 1B gives 0-a, and code 19 gives a-1. The carry flag is set when a borrow occurs (for 1B, when a is nonzero).
- R4: Code 04 gives AND, 01 gives OR and 06 gives XOR of a and b. Code 1A gives the bitwise inverse of a, 10 passes a unchanged, and 0E gives all ones. All of these clear the carry and overflow flags.
- R5: Code 1C gives a+2 and code 1D gives a-2, with bit 0 of the result equal to bit 0 of a. The carry flag reports the unsigned carry-out for 1C and the borrow for 1D.
- R6: Code 07 sets the flags exactly as code 05 would, but the result output carries the first operand unchanged.
- R7: Codes 0C, 08 and 0A move a left by one place. The vacated bit 0 receives 0 (0C), the old top bit (08) or carry_i (0A). The carry flag takes the old top bit, and overflow is the new top bit XOR the carry flag.
- R8: Codes 0D, 0F, 09 and 0B move a right by one place. The vacated top bit receives 0 (0D), the old top bit (0F), the old bit 0 (09) or carry_i (0B). The carry flag takes the old bit 0, and overflow is 0.
- R9: The zero flag is set for an all-zero result and the sign flag is the result's top bit. Overflow reports signed overflow of the arithmetic codes. Parity is 1 when the low byte of the result holds an even number of ones.
- R10: With byte_i high, every code works on bits 7:0, bit 7 serves as the top bit for all flags and fills, and result bits 15:8 read 0.
- R11: The unassigned codes 11 to 17, 1E and 1F behave as code 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 5 | Operation code |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| carry_i | input | 1 | Incoming carry flag |
| byte_i | input | 1 | Operate on the low byte only |
| result_o | output | 16 | Registered result |
| zero_o | output | 1 | Result is zero |
| sign_o | output | 1 | Top bit of result |
| carry_o | output | 1 | Carry or borrow |
| ovf_o | output | 1 | Signed overflow |
| parity_o | output | 1 | Even parity of low result byte |

## Verification
A wrong lookup word for one operation corrupts every bit of that operation's result, and the error appears one clock after the code is applied. A slip in carry-in selection or in the bit-1 injection is subtler: it moves the result by one or two, or flips only the carry flag. For that reason every code is run with both carry inputs, in both widths, and with operands at 0, all ones and the signed boundaries. A mistake on the right-moving path or in the fill selection shows up only in the top bit and the carry flag. Each registered output is compared against an independent behavioural model on every clock.

// File: rtl/lut_alu_pkg.sv
package lut_alu_pkg;
  typedef enum logic [4:0] {
    OP_ADD  = 5'h00, OP_OR   = 5'h01, OP_ADC  = 5'h02, OP_SBB  = 5'h03,
    OP_AND  = 5'h04, OP_SUB  = 5'h05, OP_XOR  = 5'h06, OP_CMP  = 5'h07,
    OP_ROL  = 5'h08, OP_ROR  = 5'h09, OP_RCL  = 5'h0A, OP_RCR  = 5'h0B,
    OP_SHL  = 5'h0C, OP_SHR  = 5'h0D, OP_ONES = 5'h0E, OP_SAR  = 5'h0F,
    OP_PASS = 5'h10, OP_INC  = 5'h18, OP_DEC  = 5'h19, OP_INV  = 5'h1A,
    OP_NEG  = 5'h1B, OP_INC2 = 5'h1C, OP_DEC2 = 5'h1D
  } op_e;

  typedef enum logic [2:0] {CIN_ZERO, CIN_ONE, CIN_CF, CIN_NCF, CIN_TOP} cin_e;
  typedef enum logic [1:0] {FILL_ZERO, FILL_TOP, FILL_LSB, FILL_CF} fill_e;

  // propagate table indexed by {a,b}; generate table indexed by b, gated by a
  localparam logic [3:0] P_XOR  = 4'b0110;
  localparam logic [3:0] P_XNOR = 4'b1001;
  localparam logic [3:0] P_AND  = 4'b1000;
  localparam logic [3:0] P_OR   = 4'b1110;
  localparam logic [3:0] P_A    = 4'b1100;
  localparam logic [3:0] P_NA   = 4'b0011;
  localparam logic [3:0] P_ONE  = 4'b1111;
  localparam logic [1:0] G_NONE = 2'b00;
  localparam logic [1:0] G_AB   = 2'b10;
  localparam logic [1:0] G_ANB  = 2'b01;
  localparam logic [1:0] G_A    = 2'b11;

  typedef struct packed {
    logic [3:0] pctl;
    logic [1:0] gctl;
    cin_e       cin;
    fill_e      fill;
    logic       borrow;
    logic       hold0;
    logic       rshift;
    logic       dup;
    logic       keep_a;
  } ctl_t;
endpackage

// File: rtl/lut_alu_slice.sv
module lut_alu_slice (
  input  logic       a_i,
  input  logic       b_i,
  input  logic       c_i,
  input  logic [3:0] pctl_i,
  input  logic [1:0] gctl_i,
  output logic       s_o,
  output logic       c_o
);
  logic p, g;
  assign p   = pctl_i[{a_i, b_i}];
  assign g   = a_i & gctl_i[b_i];
  assign s_o = p ^ c_i;
  assign c_o = g | (p & c_i);
endmodule

// File: rtl/lut_alu_decode.sv
module lut_alu_decode
  import lut_alu_pkg::*;
(
  input  logic [4:0] op_i,
  output ctl_t       ctl_o
);
  always_comb begin
    ctl_o = '{pctl: P_A, gctl: G_NONE, cin: CIN_ZERO, fill: FILL_ZERO,
              borrow: 1'b0, hold0: 1'b0, rshift: 1'b0, dup: 1'b0, keep_a: 1'b0};
    case (op_i)
      OP_ADD:  begin ctl_o.pctl = P_XOR;  ctl_o.gctl = G_AB; end
      OP_ADC:  begin ctl_o.pctl = P_XOR;  ctl_o.gctl = G_AB; ctl_o.cin = CIN_CF; end
      OP_SUB:  begin ctl_o.pctl = P_XNOR; ctl_o.gctl = G_ANB; ctl_o.cin = CIN_ONE; ctl_o.borrow = 1'b1; end
      OP_CMP:  begin ctl_o.pctl = P_XNOR; ctl_o.gctl = G_ANB; ctl_o.cin = CIN_ONE; ctl_o.borrow = 1'b1;
                     ctl_o.keep_a = 1'b1; end
      OP_SBB:  begin ctl_o.pctl = P_XNOR; ctl_o.gctl = G_ANB; ctl_o.cin = CIN_NCF; ctl_o.borrow = 1'b1; end
      OP_AND:  ctl_o.pctl = P_AND;
      OP_OR:   ctl_o.pctl = P_OR;
      OP_XOR:  ctl_o.pctl = P_XOR;
      OP_INV:  ctl_o.pctl = P_NA;
      OP_ONES: ctl_o.pctl = P_ONE;
      OP_INC:  ctl_o.cin = CIN_ONE;
      OP_DEC:  begin ctl_o.pctl = P_NA; ctl_o.gctl = G_A; ctl_o.borrow = 1'b1; end
      OP_NEG:  begin ctl_o.pctl = P_NA; ctl_o.cin = CIN_ONE; ctl_o.borrow = 1'b1; end
      OP_INC2: begin ctl_o.cin = CIN_ONE; ctl_o.hold0 = 1'b1; end
      OP_DEC2: begin ctl_o.pctl = P_NA; ctl_o.gctl = G_A; ctl_o.borrow = 1'b1; ctl_o.hold0 = 1'b1; end
      // left moves: operand added to itself
      OP_SHL:  begin ctl_o.pctl = P_XOR; ctl_o.gctl = G_AB; ctl_o.dup = 1'b1; end
      OP_ROL:  begin ctl_o.pctl = P_XOR; ctl_o.gctl = G_AB; ctl_o.dup = 1'b1; ctl_o.cin = CIN_TOP; end
      OP_RCL:  begin ctl_o.pctl = P_XOR; ctl_o.gctl = G_AB; ctl_o.dup = 1'b1; ctl_o.cin = CIN_CF; end
      OP_SHR:  ctl_o.rshift = 1'b1;
      OP_SAR:  begin ctl_o.rshift = 1'b1; ctl_o.fill = FILL_TOP; end
      OP_ROR:  begin ctl_o.rshift = 1'b1; ctl_o.fill = FILL_LSB; end
      OP_RCR:  begin ctl_o.rshift = 1'b1; ctl_o.fill = FILL_CF; end
      default: ;
    endcase
  end
endmodule

// File: rtl/lut_alu.sv
module lut_alu
  import lut_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [4:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         carry_i,
  input  logic         byte_i,
  output logic [W-1:0] result_o,
  output logic         zero_o,
  output logic         sign_o,
  output logic         carry_o,
  output logic         ovf_o,
  output logic         parity_o
);
  localparam int BW = 8;
  localparam logic [W-1:0] BYTE_MASK = {{(W-BW){1'b0}}, {BW{1'b1}}};

  ctl_t ctl;
  lut_alu_decode u_dec (.op_i(op_i), .ctl_o(ctl));

  logic [W-1:0] b_eff, sum, c_in, c_out, shr_res, mask, raw, res_d;
  logic top_a, cin0, fill, cout_eff, cin_top, carry_d, ovf_d;

  assign b_eff = ctl.dup ? a_i : b_i;
  assign top_a = byte_i ? a_i[BW-1] : a_i[W-1];

  always_comb begin
    case (ctl.cin)
      CIN_ONE: cin0 = 1'b1;
      CIN_CF:  cin0 = carry_i;
      CIN_NCF: cin0 = ~carry_i;
      CIN_TOP: cin0 = top_a;
      default: cin0 = 1'b0;
    endcase
  end

  for (genvar i = 0; i < W; i++) begin : g_slice
    logic [3:0] pl;
    logic [1:0] gl;
    if (i == 0) begin : g_lsb
      // bit 0 passes through when the step is injected at bit 1
      assign pl      = ctl.hold0 ? P_A : ctl.pctl;
      assign gl      = ctl.hold0 ? G_NONE : ctl.gctl;
      assign c_in[0] = ctl.hold0 ? 1'b0 : cin0;
    end else if (i == 1) begin : g_b1
      assign pl      = ctl.pctl;
      assign gl      = ctl.gctl;
      assign c_in[1] = ctl.hold0 ? cin0 : c_out[0];
    end else begin : g_up
      assign pl      = ctl.pctl;
      assign gl      = ctl.gctl;
      assign c_in[i] = c_out[i-1];
    end
    lut_alu_slice u_slice (
      .a_i(a_i[i]), .b_i(b_eff[i]), .c_i(c_in[i]),
      .pctl_i(pl), .gctl_i(gl), .s_o(sum[i]), .c_o(c_out[i])
    );
  end

  always_comb begin
    case (ctl.fill)
      FILL_TOP: fill = top_a;
      FILL_LSB: fill = a_i[0];
      FILL_CF:  fill = carry_i;
      default:  fill = 1'b0;
    endcase
  end

  always_comb begin
    shr_res = '0;
    if (byte_i) shr_res[BW-1:0] = {fill, a_i[BW-1:1]};
    else        shr_res         = {fill, a_i[W-1:1]};
  end

  assign mask     = byte_i ? BYTE_MASK : '1;
  assign raw      = (ctl.rshift ? shr_res : sum) & mask;
  assign res_d    = (ctl.keep_a ? a_i : raw) & mask;
  assign cout_eff = byte_i ? c_out[BW-1] : c_out[W-1];
  assign cin_top  = byte_i ? c_in[BW-1]  : c_in[W-1];
  assign carry_d  = ctl.rshift ? a_i[0] : (ctl.borrow ^ cout_eff);
  assign ovf_d    = ctl.rshift ? 1'b0 : (cin_top ^ cout_eff);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      zero_o   <= 1'b0;
      sign_o   <= 1'b0;
      carry_o  <= 1'b0;
      ovf_o    <= 1'b0;
      parity_o <= 1'b0;
    end else begin
      result_o <= res_d;
      zero_o   <= (raw == '0);
      sign_o   <= byte_i ? raw[BW-1] : raw[W-1];
      carry_o  <= carry_d;
      ovf_o    <= ovf_d;
      parity_o <= ~^raw[BW-1:0];
    end
  end

  AST_CMP_KEEPS_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_CMP && !byte_i) |=> result_o == $past(a_i)); // R6
  AST_CMP_EQUAL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_CMP && a_i == b_i) |=> (zero_o && !carry_o && !ovf_o)); // R6
  AST_LOGIC_NO_CV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR) |=> (!carry_o && !ovf_o)); // R4
  AST_BYTE_UPPER_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_i |=> result_o[W-1:BW] == '0); // R10
  AST_SHR_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_SHR) |=> (carry_o == $past(a_i[0]) && !ovf_o)); // R8
  AST_ADD_ZERO_ID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_ADD && b_i == '0 && !byte_i) |=> (result_o == $past(a_i) && !carry_o)); // R2
endmodule

// File: tb/lut_alu_test.sv
module lut_alu_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  op = '0;
  logic [15:0] a = '0, b = '0;
  logic        cf = 1'b0, bm = 1'b0;
  logic [15:0] result;
  logic        zero, sign, carry, ovf, parity;

  int total = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lut_alu uut (
    .clk_i(clk), .rst_ni(rst_ni), .op_i(op), .a_i(a), .b_i(b),
    .carry_i(cf), .byte_i(bm), .result_o(result), .zero_o(zero),
    .sign_o(sign), .carry_o(carry), .ovf_o(ovf), .parity_o(parity)
  );

  function automatic logic [20:0] ref_alu(input logic [4:0] o_, input logic [15:0] a_,
                                          input logic [15:0] b_, input logic c_, input logic m_);
    longint w, top, mask, x, y, sx, sy, full, sr, r, rf;
    logic c, v, z, s, p, arith;
    logic [7:0] lo;
    w = m_ ? 8 : 16; top = w - 1; mask = (64'sd1 <<< w) - 1;
    x = longint'(a_) & mask; y = longint'(b_) & mask;
    sx = (x >= (64'sd1 <<< top)) ? x - (64'sd1 <<< w) : x;
    sy = (y >= (64'sd1 <<< top)) ? y - (64'sd1 <<< w) : y;
    c = 0; v = 0; arith = 0; r = x; full = 0; sr = 0;
    case (o_)
      5'h00: begin full = x + y;        sr = sx + sy;        c = full > mask; arith = 1; end
      5'h02: begin full = x + y + c_;   sr = sx + sy + c_;   c = full > mask; arith = 1; end
      5'h05, 5'h07: begin full = x - y; sr = sx - sy;        c = x < y;       arith = 1; end
      5'h03: begin full = x - y - c_;   sr = sx - sy - c_;   c = x < y + c_;  arith = 1; end
      5'h18: begin full = x + 1;        sr = sx + 1;         c = x == mask;   arith = 1; end
      5'h19: begin full = x - 1;        sr = sx - 1;         c = x == 0;      arith = 1; end
      5'h1C: begin full = x + 2;        sr = sx + 2;         c = x + 2 > mask; arith = 1; end
      5'h1D: begin full = x - 2;        sr = sx - 2;         c = x < 2;       arith = 1; end
      5'h1B: begin full = -x;           sr = -sx;            c = x != 0;      arith = 1; end
      5'h01: r = x | y;
      5'h04: r = x & y;
      5'h06: r = x ^ y;
      5'h1A: r = ~x & mask;
      5'h0E: r = mask;
      5'h0C, 5'h08, 5'h0A: begin
        c = ((x >>> top) & 1) != 0;
        r = (x <<< 1) & mask;
        if (o_ == 5'h08) r = r | longint'(c);
        if (o_ == 5'h0A) r = r | longint'(c_);
        v = (((r >>> top) & 1) != 0) ^ c;
      end
      5'h0D, 5'h0F, 5'h09, 5'h0B: begin
        c = (x & 1) != 0;
        r = x >>> 1;
        if (o_ == 5'h0F) r = r | (x & (64'sd1 <<< top));
        if (o_ == 5'h09) r = r | ((x & 1) <<< top);
        if (o_ == 5'h0B) r = r | (longint'(c_) <<< top);
      end
      default: r = x;
    endcase
    if (arith) begin
      r = full & mask;
      v = (sr < -(64'sd1 <<< top)) || (sr > (64'sd1 <<< top) - 1);
    end
    rf = r;
    if (o_ == 5'h07) r = x;
    z = (rf == 0);
    s = ((rf >>> top) & 1) != 0;
    lo = rf[7:0];
    p = ~^lo;
    return {r[15:0], z, s, c, v, p};
  endfunction

  function automatic string req_of(input logic [4:0] o_, input logic m_);
    if (m_) return "R10";
    case (o_)
      5'h00, 5'h02, 5'h18:                      return "R2";
      5'h03, 5'h05, 5'h19, 5'h1B:               return "R3";
      5'h01, 5'h04, 5'h06, 5'h1A, 5'h10, 5'h0E: return "R4";
      5'h1C, 5'h1D:                             return "R5";
      5'h07:                                    return "R6";
      5'h08, 5'h0A, 5'h0C:                      return "R7";
      5'h09, 5'h0B, 5'h0D, 5'h0F:               return "R8";
      default:                                  return "R11";
    endcase
  endfunction

  logic [20:0] exp_q;
  logic [4:0]  op_q;
  logic        bm_q;
  bit          pend = 1'b0;

  task automatic compare();
    string t;
    t = req_of(op_q, bm_q);
    total++;
    if (result !== exp_q[20:5]) begin
      fails++;
      $display("FAIL %s op=%h result act=%h exp=%h", t, op_q, result, exp_q[20:5]);
    end
    total++; // flags: R9 (R10 in byte mode, R6 for compare)
    if ({zero, sign, carry, ovf, parity} !== exp_q[4:0]) begin
      fails++;
      $display("FAIL %s/R9 op=%h flags zscvp act=%b exp=%b", t, op_q,
               {zero, sign, carry, ovf, parity}, exp_q[4:0]);
    end
  endtask

  // drive at the falling edge; check the previous vector one clock later (R1 latency)
  task automatic step(input logic [4:0] o_, input logic [15:0] a_, input logic [15:0] b_,
                      input logic c_, input logic m_);
    @(negedge clk);
    if (pend) compare();
    op = o_; a = a_; b = b_; cf = c_; bm = m_;
    exp_q = ref_alu(o_, a_, b_, c_, m_);
    op_q = o_; bm_q = m_; pend = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    total++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  logic [15:0] vals [10] = '{16'h0000, 16'hFFFF, 16'h8000, 16'h7FFF, 16'h0001,
                             16'h0002, 16'h1234, 16'h00FF, 16'h0080, 16'hA5C3};

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    total++;
    if ({result, zero, sign, carry, ovf, parity} !== 21'd0) begin
      fails++;
      $display("FAIL R1 reset act=%h exp=0", {result, zero, sign, carry, ovf, parity});
    end
    rst_ni = 1'b1;
    for (int o = 0; o < 32; o++)
      for (int m = 0; m < 2; m++)
        for (int c = 0; c < 2; c++)
          for (int i = 0; i < 10; i++)
            step(5'(o), vals[i], (i % 3 == 0) ? vals[i] : vals[(i * 3 + 1) % 10], c[0], m[0]);
    for (int k = 0; k < 2000; k++)
      step(5'($urandom_range(0, 31)), 16'($urandom), 16'($urandom),
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    @(negedge clk);
    compare();
    pend = 1'b0;
    finish_run();
  end
endmodule